// File: doc/BRIEF.md
# Receive-Side Software Flow-Control Detector

This block sits behind a UART receiver. It inspects every completed character against four programmable flow characters: two resume characters (set 1 and set 2) and two pause characters (set 1 and set 2). A receive-mode field selects which set is compared. In the dual-set mode, a character from either set is accepted, or the set-1 character must be followed by the set-2 character, depending on the transmit-mode field. Each recognised pause raises `tx_pause`, which halts the local transmitter, and each recognised resume lowers it. Flow characters consumed this way are not written to the receive FIFO. All other characters are passed on through `fifo_wr`/`fifo_data`.

A special-character option compares every character with the set-2 pause character and raises a sticky flag on a match. The matching character still goes to the FIFO, unless flow control has already consumed it.

The mode bits sit behind a write gate. They change only while a stored enable bit is 1, so clearing that bit freezes them. Both interrupt flags stay set until `irq_clr` is pulsed.

Top module: `uart_swfc_detect`

## Requirements
- R1: After reset, `fifo_wr`, `tx_pause`, `xoff_irq`, `spec_irq` and all bits of `cfg_rdata` are 0.
- R2: The config word has this layout: bit 5 is the gate enable, bit 4 is the special enable, bits 3:2 are the transmit mode and bits 1:0 are the receive mode. A `cfg_we` write always updates bit 5. Bits 4:0 are updated only when the stored bit 5 is already 1; otherwise they keep their values.
- R3: With receive mode 00, no character changes `tx_pause` or `xoff_irq`, and every character is forwarded unchanged.
- R4: A recognised pause character sets `tx_pause` and `xoff_irq`. A recognised resume character clears `tx_pause`. Neither character is forwarded.
- R5: Receive mode 01 recognises only the set-2 characters and mode 10 only the set-1 characters. Mode 11 with transmit mode 01 or 10 recognises a character from either set on its own. Unrecognised characters are forwarded.
- R6: With the special enable set, a character equal to the set-2 pause character sets `spec_irq`. In receive mode 10 that character is forwarded.
- R7: In receive mode 01, a character equal to the set-2 pause character is not forwarded and sets both `xoff_irq` and `spec_irq` (when the special enable is set).
- R8: `xoff_irq` and `spec_irq` stay set until `irq_clr` is 1 for a cycle. A new detection in that same cycle keeps the flag set.
- R9: Receive mode 11 with transmit mode 00 or 11 acts on pairs. A set-1 pause immediately followed by a set-2 pause is a pause, and a set-1 resume followed by a set-2 resume is a resume. Neither character of a completed pair is forwarded.
- R10: If the character after a held first character does not complete its pair, the held character is forwarded in the next cycle. The new character is then evaluated from idle and its result appears one cycle later.
- R11: The result for a character (forward, flag or pause change) appears in the cycle after `rx_valid`. The only exception is the re-evaluation in R10.
- R12: `rx_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Completed character strobe |
| rx_data | input | DATA_W | Received character |
| xon1_chr | input | DATA_W | Set-1 resume character |
| xon2_chr | input | DATA_W | Set-2 resume character |
| xoff1_chr | input | DATA_W | Set-1 pause character |
| xoff2_chr | input | DATA_W | Set-2 pause / special character |
| cfg_we | input | 1 | Config write strobe |
| cfg_wdata | input | 6 | Config write word |
| cfg_rdata | output | 6 | Current config word |
| irq_clr | input | 1 | Clears both interrupt flags |
| fifo_wr | output | 1 | Write strobe to receive FIFO |
| fifo_data | output | DATA_W | Character to the FIFO |
| tx_pause | output | 1 | Holds the local transmitter |
| xoff_irq | output | 1 | Sticky pause-detected flag |
| spec_irq | output | 1 | Sticky special-character flag |

## Verification
The only hidden state is the pair-hold register and its replay slot. If they were wrong, the bench would see it one or two cycles after the second character of a pair: a swallowed data byte, a duplicated or reordered FIFO write, or a `tx_pause` change that should not happen. A frozen or leaking config gate shows directly on `cfg_rdata` in the cycle after the write. The scoreboard compares each FIFO write in order as it appears, so a wrong forward decision is reported at the first write it affects.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
   typedef enum logic [1:0] {
      FM_OFF  = 2'b00,
      FM_SET2 = 2'b01,
      FM_SET1 = 2'b10,
      FM_BOTH = 2'b11
   } fmode_e;

   typedef struct packed {
      logic   enh_en;
      logic   spec_en;
      fmode_e tx_mode;
      fmode_e rx_mode;
   } cfg_t;

   typedef enum logic [1:0] {
      HOLD_NONE = 2'b00,
      HOLD_XON  = 2'b01,
      HOLD_XOFF = 2'b10
   } hold_e;

   localparam int CFG_W = $bits(cfg_t);
   // reference slots in the comparator bank
   localparam int REF_XON1  = 0;
   localparam int REF_XON2  = 1;
   localparam int REF_XOFF1 = 2;
   localparam int REF_XOFF2 = 3;
   localparam int NREF      = 4;
endpackage

// File: rtl/swfc_cfg_gate.sv
module swfc_cfg_gate
   import swfc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic we,
   input  cfg_t wdata,
   output cfg_t cfg
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (we) begin
         cfg.enh_en <= wdata.enh_en;
         if (cfg.enh_en) begin
            cfg.spec_en <= wdata.spec_en;
            cfg.tx_mode <= wdata.tx_mode;
            cfg.rx_mode <= wdata.rx_mode;
         end
      end
   end
endmodule

// File: rtl/swfc_char_match.sv
module swfc_char_match
   import swfc_pkg::*;
#(
   parameter int DATA_W = 8
)(
   input  logic [DATA_W-1:0] chr,
   input  logic [DATA_W-1:0] xon1,
   input  logic [DATA_W-1:0] xon2,
   input  logic [DATA_W-1:0] xoff1,
   input  logic [DATA_W-1:0] xoff2,
   output logic [NREF-1:0]   hit
);
   logic [DATA_W-1:0] refs [NREF];

   assign refs[REF_XON1]  = xon1;
   assign refs[REF_XON2]  = xon2;
   assign refs[REF_XOFF1] = xoff1;
   assign refs[REF_XOFF2] = xoff2;

   for (genvar g = 0; g < NREF; g++) begin : g_cmp
      assign hit[g] = (chr == refs[g]);
   end
endmodule

// File: rtl/swfc_decide.sv
module swfc_decide
   import swfc_pkg::*;
#(
   parameter bit PAIR_EN = 1'b1
)(
   input  logic            ev_valid,
   input  logic [NREF-1:0] hit,
   input  fmode_e          rx_mode,
   input  fmode_e          tx_mode,
   input  logic            spec_en,
   input  hold_e           hold,
   output logic            fwd_new,
   output logic            fwd_held,
   output hold_e           hold_nxt,
   output logic            replay,
   output logic            det_xon,
   output logic            det_xoff,
   output logic            det_spec
);
   logic pair_mode;
   logic s_xon;
   logic s_xoff;

   if (PAIR_EN) begin : g_pair
      assign pair_mode = (rx_mode == FM_BOTH) &&
                         ((tx_mode == FM_OFF) || (tx_mode == FM_BOTH));
   end else begin : g_nopair
      assign pair_mode = 1'b0;
   end

   always_comb begin
      unique case (rx_mode)
         FM_SET2: begin
            s_xon  = hit[REF_XON2];
            s_xoff = hit[REF_XOFF2];
         end
         FM_SET1: begin
            s_xon  = hit[REF_XON1];
            s_xoff = hit[REF_XOFF1];
         end
         FM_BOTH: begin
            s_xon  = hit[REF_XON1] | hit[REF_XON2];
            s_xoff = hit[REF_XOFF1] | hit[REF_XOFF2];
         end
         default: begin
            s_xon  = 1'b0;
            s_xoff = 1'b0;
         end
      endcase
   end

   always_comb begin
      fwd_new  = 1'b0;
      fwd_held = 1'b0;
      hold_nxt = hold;
      replay   = 1'b0;
      det_xon  = 1'b0;
      det_xoff = 1'b0;
      if (ev_valid) begin
         if (hold != HOLD_NONE) begin
            hold_nxt = HOLD_NONE;
            if (pair_mode && hold == HOLD_XOFF && hit[REF_XOFF2]) begin
               det_xoff = 1'b1;
            end else if (pair_mode && hold == HOLD_XON && hit[REF_XON2]) begin
               det_xon = 1'b1;
            end else begin
               fwd_held = 1'b1;
               replay   = 1'b1;
            end
         end else if (pair_mode) begin
            if (hit[REF_XOFF1])     hold_nxt = HOLD_XOFF;
            else if (hit[REF_XON1]) hold_nxt = HOLD_XON;
            else                    fwd_new  = 1'b1;
         end else begin
            det_xoff = s_xoff;
            det_xon  = s_xon & ~s_xoff;
            fwd_new  = ~(s_xon | s_xoff);
         end
      end
   end

   assign det_spec = ev_valid & spec_en & hit[REF_XOFF2] & ~replay;
endmodule

// File: rtl/uart_swfc_detect.sv
module uart_swfc_detect
   import swfc_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit PAIR_EN = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic [DATA_W-1:0] xon1_chr,
   input  logic [DATA_W-1:0] xon2_chr,
   input  logic [DATA_W-1:0] xoff1_chr,
   input  logic [DATA_W-1:0] xoff2_chr,
   input  logic              cfg_we,
   input  logic [5:0]        cfg_wdata,
   output logic [5:0]        cfg_rdata,
   input  logic              irq_clr,
   output logic              fifo_wr,
   output logic [DATA_W-1:0] fifo_data,
   output logic              tx_pause,
   output logic              xoff_irq,
   output logic              spec_irq
);
   if (DATA_W < 1) begin : g_bad_w
      $error("DATA_W must be at least 1");
   end
   if (CFG_W != 6) begin : g_bad_cfg
      $error("config word width mismatch");
   end

   cfg_t              cfg;
   logic [NREF-1:0]   hit;
   hold_e             hold_q, hold_nxt;
   logic [DATA_W-1:0] held_q;
   logic              replay_q;
   logic [DATA_W-1:0] replay_d_q;
   logic              ev_valid;
   logic [DATA_W-1:0] ev_data;
   logic              fwd_new, fwd_held, set_replay;
   logic              det_xon, det_xoff, det_spec;

   swfc_cfg_gate u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_t'(cfg_wdata)),
      .cfg   (cfg)
   );
   assign cfg_rdata = cfg;

   assign ev_valid = rx_valid | replay_q;
   assign ev_data  = replay_q ? replay_d_q : rx_data;

   swfc_char_match #(.DATA_W(DATA_W)) u_match (
      .chr   (ev_data),
      .xon1  (xon1_chr),
      .xon2  (xon2_chr),
      .xoff1 (xoff1_chr),
      .xoff2 (xoff2_chr),
      .hit   (hit)
   );

   swfc_decide #(.PAIR_EN(PAIR_EN)) u_dec (
      .ev_valid (ev_valid),
      .hit      (hit),
      .rx_mode  (cfg.rx_mode),
      .tx_mode  (cfg.tx_mode),
      .spec_en  (cfg.spec_en),
      .hold     (hold_q),
      .fwd_new  (fwd_new),
      .fwd_held (fwd_held),
      .hold_nxt (hold_nxt),
      .replay   (set_replay),
      .det_xon  (det_xon),
      .det_xoff (det_xoff),
      .det_spec (det_spec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q     <= HOLD_NONE;
         held_q     <= '0;
         replay_q   <= 1'b0;
         replay_d_q <= '0;
         fifo_wr    <= 1'b0;
         fifo_data  <= '0;
         tx_pause   <= 1'b0;
         xoff_irq   <= 1'b0;
         spec_irq   <= 1'b0;
      end else begin
         hold_q   <= hold_nxt;
         replay_q <= set_replay;
         if (set_replay) replay_d_q <= ev_data;
         if (ev_valid && hold_q == HOLD_NONE && hold_nxt != HOLD_NONE)
            held_q <= ev_data;
         fifo_wr   <= fwd_new | fwd_held;
         fifo_data <= fwd_held ? held_q : ev_data;
         if (det_xoff)     tx_pause <= 1'b1;
         else if (det_xon) tx_pause <= 1'b0;
         xoff_irq <= det_xoff | (xoff_irq & ~irq_clr);
         spec_irq <= det_spec | (spec_irq & ~irq_clr);
      end
   end
endmodule

// File: rtl/swfc_check.sv
module swfc_check #(
   parameter int DATA_W = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid,
   input logic [5:0]        cfg_rdata,
   input logic              irq_clr,
   input logic              fifo_wr,
   input logic [DATA_W-1:0] fifo_data,
   input logic              tx_pause,
   input logic              xoff_irq,
   input logic              spec_irq
);
   logic unused_ok;
   assign unused_ok = ^fifo_data;

   assert_rx_gap_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   assert_fwd_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr |-> ($past(rx_valid) || $past(rx_valid, 2)));

   assert_pause_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_pause) |-> xoff_irq);

   assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (xoff_irq && !irq_clr) |=> xoff_irq);

   assert_spec_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (spec_irq && !irq_clr) |=> spec_irq);

   assert_spec_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spec_irq) |-> $past(cfg_rdata[4]));

   assert_mode_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_rdata[1:0]) == 2'b00) |-> ($stable(tx_pause) && !$rose(xoff_irq)));

   assert_gate_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_rdata[5]) |-> $stable(cfg_rdata[4:0]));
endmodule

bind uart_swfc_detect swfc_check #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_valid  (rx_valid),
   .cfg_rdata (cfg_rdata),
   .irq_clr   (irq_clr),
   .fifo_wr   (fifo_wr),
   .fifo_data (fifo_data),
   .tx_pause  (tx_pause),
   .xoff_irq  (xoff_irq),
   .spec_irq  (spec_irq)
);

// File: tb/sim_uart_swfc_detect.sv
`timescale 1ns/1ps
module sim_uart_swfc_detect;
   localparam int W = 8;
   localparam logic [W-1:0] XON1 = 8'h11, XON2 = 8'h21, XOFF1 = 8'h13, XOFF2 = 8'h23;

   logic clk = 1'b0, rst_n = 1'b0, rx_valid = 1'b0, cfg_we = 1'b0, irq_clr = 1'b0;
   logic [W-1:0] rx_data = '0;
   logic [5:0]   cfg_wdata = '0;
   logic [5:0]   cfg_rdata;
   logic         fifo_wr, tx_pause, xoff_irq, spec_irq;
   logic [W-1:0] fifo_data;

   int errors = 0, checks = 0;
   logic [W-1:0] exp_q [$];
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   uart_swfc_detect #(.DATA_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .xon1_chr(XON1), .xon2_chr(XON2), .xoff1_chr(XOFF1), .xoff2_chr(XOFF2),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .irq_clr(irq_clr), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
      .tx_pause(tx_pause), .xoff_irq(xoff_irq), .spec_irq(spec_irq));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: every FIFO write is compared in order against the queue
   always @(negedge clk) begin
      if (rst_n && fifo_wr) begin
         if (exp_q.size() == 0) chk("R3/R10 unexpected write", int'(fifo_data), -1);
         else chk("R11 fifo order", int'(fifo_data), int'(exp_q.pop_front()));
      end
   end

   task automatic wcfg(input logic [5:0] w);
      @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   // driver: push expected forwards, then strobe the character
   task automatic send(input logic [W-1:0] d, input bit fwd);
      if (fwd) exp_q.push_back(d);
      @(negedge clk); rx_valid = 1'b1; rx_data = d;
      @(negedge clk); rx_valid = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic clr_irq;
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 fifo_wr", fifo_wr, 0);
      chk("R1 tx_pause", tx_pause, 0);
      chk("R1 irqs", {xoff_irq, spec_irq}, 0);
      chk("R1 cfg", cfg_rdata, 0);

      // R2: gate closed, fields ignored
      wcfg(6'b0_0_00_10);
      chk("R2 closed gate", cfg_rdata, 6'h00);
      wcfg(6'b1_0_00_00);
      chk("R2 enable", cfg_rdata, 6'h20);

      // R3: mode 00 forwards flow chars
      send(XOFF1, 1);
      send(XON2, 1);
      chk("R3 no pause", tx_pause, 0);
      chk("R3 no irq", xoff_irq, 0);

      // mode 10, special on
      wcfg(6'b1_1_00_10);
      chk("R2 fields written", cfg_rdata, 6'h32);
      send(8'h41, 1);
      send(XOFF1, 0);
      chk("R4 pause set", tx_pause, 1);
      chk("R4 xoff irq", xoff_irq, 1);
      send(XOFF2, 1);
      chk("R6 spec irq", spec_irq, 1);
      chk("R6 pause kept", tx_pause, 1);
      send(XON2, 1);
      chk("R5 set2 ignored in mode10", tx_pause, 1);
      send(XON1, 0);
      chk("R4 pause cleared", tx_pause, 0);
      chk("R8 sticky xoff", xoff_irq, 1);
      clr_irq();
      chk("R8 cleared", {xoff_irq, spec_irq}, 0);

      // R7: mode 01 swallows xoff2
      wcfg(6'b1_1_00_01);
      send(XOFF2, 0);
      chk("R7 pause", tx_pause, 1);
      chk("R7 both irqs", {xoff_irq, spec_irq}, 2'b11);
      send(XON1, 1);
      chk("R5 set1 ignored in mode01", tx_pause, 1);
      send(XON2, 0);
      chk("R5 set2 resume", tx_pause, 0);
      clr_irq();

      // R5: mode 11 with tx 01 accepts either set
      wcfg(6'b1_0_01_11);
      send(XOFF1, 0);
      chk("R5 either xoff1", tx_pause, 1);
      send(XON2, 0);
      chk("R5 either xon2", tx_pause, 0);
      clr_irq();

      // R9/R10: pair mode (rx 11, tx 11)
      wcfg(6'b1_0_11_11);
      send(XOFF1, 0);
      chk("R9 held, no pause yet", tx_pause, 0);
      send(XOFF2, 0);
      chk("R9 pair pause", tx_pause, 1);
      send(XON1, 0);
      send(XON2, 0);
      chk("R9 pair resume", tx_pause, 0);
      send(XOFF1, 0);
      exp_q.push_back(XOFF1);
      send(8'h55, 1);
      chk("R10 broken pair no pause", tx_pause, 0);
      send(XOFF1, 0);
      exp_q.push_back(XOFF1);
      send(XOFF1, 0);
      send(XOFF2, 0);
      chk("R10 replayed first char pairs", tx_pause, 1);
      send(XON2, 1);
      chk("R9 lone xon2 forwarded", tx_pause, 1);

      // R2: freeze
      wcfg(6'b0_0_11_11);
      wcfg(6'b0_1_00_01);
      chk("R2 frozen", cfg_rdata, 6'h0F);

      repeat (4) @(negedge clk);
      chk("R11 queue drained", exp_q.size(), 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule